// File: doc/BRIEF.md
# Programmable Interrupt Event Router

This block gathers many system event lines and turns them into a smaller set of host interrupt lines. Each event line has a sticky status bit. The bit is set when the line rises, or when software writes the event's number to a set register. It stays set until software writes the event's number to a clear register. Software steers each event to a channel by writing that event's entry in a map table. A channel always drives the host output with the same number, so picking a channel also picks the host line.

Two enable levels gate the path. A per-event enable lets a pending event reach its channel. A per-host enable and one global enable together let a channel drive its host output. Host outputs come in slices of eight per processor core: slot k of core c is output k + 8*c. Software therefore reaches a core by choosing a channel inside that core's slice.

A single write port and an address-decoded read path give software access to the map, the enables, the raw status bits and a pending view per channel. The pending view shows each channel's OR before the host enables are applied.

Top module: `evr_router`

## Requirements
- R1: After reset, all status bits, per-event enables, per-host enables, the global enable (bit 0 at address 0) and `host_irq` are zero, and every map entry (address 32+e, bits [3:0]) reads channel 0.
- R2: A rising edge on `sys_evt[e]` sets status bit e. A line held high does not set the bit again after it has been cleared. Status bits never drop except through a clear write.
- R3: Writing index e to the set register (address 1) sets status bit e. An index at or above the number of events changes nothing.
- R4: Writing index e to the clear register (address 2) clears status bit e. If a rising edge on the same input falls in the same cycle, the clear wins.
- R5: Bit ch of the pending view (address 6) is the OR of status[e] AND enable[e] over all events e whose map entry equals ch. Several events may share one channel.
- R6: Status bits (address 5) record events while the input is disabled. Setting the enable later (address 3, bit e) makes the pending event reach its channel.
- R7: `host_irq[ch]` is high exactly one cycle after pending[ch], host enable ch (address 4, bit ch) and the global enable are all high. It is low whenever any one of these was low in the previous cycle.
- R8: Channel ch drives only `host_irq[ch]`, with no remapping. Slot k of core c is host line k + 8*c.
- R9: The control, enable and map registers read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_evt | input | NUM_EVT | System event lines, edge-detected |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| host_irq | output | 8*NUM_CORES | Registered host interrupt lines |

## Verification
The bench sweeps every event across a low channel, a high channel and a slot in the second core's slice. A mistake in the map decode or in the one-to-one channel-to-host wiring would light the wrong host line or no line at all.

It lines up a rising edge with a clear write in the same cycle. A design that favoured the set would leave the bit pending. It then holds the line high: a level-sensitive latch would set the bit again. It fires an event while the input is disabled, to catch designs that drop the event rather than hold it. It writes set indices beyond the event count, which a design with a loose index check would turn into false status bits.

Finally, it samples the host line one cycle after the pending view rises and again one cycle later. This exposes an unregistered output or an extra pipeline stage.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 6;
    localparam int IDX_MAX_W      = 5;
    localparam int HOSTS_PER_CORE = 8;

    localparam logic [ADDR_W-1:0] A_CTRL     = 6'd0;
    localparam logic [ADDR_W-1:0] A_SET      = 6'd1;
    localparam logic [ADDR_W-1:0] A_CLR      = 6'd2;
    localparam logic [ADDR_W-1:0] A_EVT_EN   = 6'd3;
    localparam logic [ADDR_W-1:0] A_HOST_EN  = 6'd4;
    localparam logic [ADDR_W-1:0] A_STATUS   = 6'd5;
    localparam logic [ADDR_W-1:0] A_PEND     = 6'd6;
    localparam logic [ADDR_W-1:0] A_MAP_BASE = 6'd32;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CTRL,
        OP_SET,
        OP_CLR,
        OP_EVT_EN,
        OP_HOST_EN,
        OP_STATUS,
        OP_PEND_OR_MAP
    } reg_op_e;

    // index strobe used for set-by-number and clear-by-number
    typedef struct packed {
        logic                 vld;
        logic [IDX_MAX_W-1:0] idx;
    } idx_strobe_t;

    function automatic reg_op_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_op_e op;
        case (a)
            A_CTRL:    op = OP_CTRL;
            A_SET:     op = OP_SET;
            A_CLR:     op = OP_CLR;
            A_EVT_EN:  op = OP_EVT_EN;
            A_HOST_EN: op = OP_HOST_EN;
            A_STATUS:  op = OP_STATUS;
            default:   op = (a >= A_MAP_BASE || a == A_PEND) ? OP_PEND_OR_MAP : OP_NONE;
        endcase
        return op;
    endfunction

    function automatic int host_index(input int core, input int slot);
        return slot + HOSTS_PER_CORE * core;
    endfunction

endpackage

// File: rtl/evr_regs.sv
module evr_regs
    import evr_pkg::*;
#(
    parameter int NUM_EVT = 12,
    parameter int NUM_CH  = 16,
    parameter int CH_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NUM_EVT-1:0]             status,
    input  logic [NUM_CH-1:0]              pend,
    output logic [DATA_W-1:0]              rdata,
    output logic                           glob_en,
    output logic [NUM_EVT-1:0]             evt_en,
    output logic [NUM_CH-1:0]              host_en,
    output logic [NUM_EVT-1:0][CH_W-1:0]   map_q,
    output idx_strobe_t                    set_s,
    output idx_strobe_t                    clr_s
);

    reg_op_e           op;
    logic              idx_ok;
    logic [ADDR_W-1:0] moff;
    logic              map_win;

    assign op      = decode_addr(addr);
    assign idx_ok  = wdata < DATA_W'(NUM_EVT);
    assign moff    = addr - A_MAP_BASE;
    assign map_win = (addr >= A_MAP_BASE) && (moff < ADDR_W'(NUM_EVT));

    assign set_s.vld = wr_en && (op == OP_SET) && idx_ok;
    assign set_s.idx = wdata[IDX_MAX_W-1:0];
    assign clr_s.vld = wr_en && (op == OP_CLR) && idx_ok;
    assign clr_s.idx = wdata[IDX_MAX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
            evt_en  <= '0;
            host_en <= '0;
        end else if (wr_en) begin
            case (op)
                OP_CTRL:    glob_en <= wdata[0];
                OP_EVT_EN:  evt_en  <= wdata[NUM_EVT-1:0];
                OP_HOST_EN: host_en <= wdata[NUM_CH-1:0];
                default:    ;
            endcase
        end
    end

    generate
        for (genvar e = 0; e < NUM_EVT; e++) begin : g_map
            always_ff @(posedge clk) begin
                if (rst)
                    map_q[e] <= '0;
                else if (wr_en && map_win && moff == ADDR_W'(e))
                    map_q[e] <= wdata[CH_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (op)
            OP_CTRL:    rdata[0]          = glob_en;
            OP_EVT_EN:  rdata[NUM_EVT-1:0] = evt_en;
            OP_HOST_EN: rdata[NUM_CH-1:0]  = host_en;
            OP_STATUS:  rdata[NUM_EVT-1:0] = status;
            OP_PEND_OR_MAP: begin
                if (addr == A_PEND)
                    rdata[NUM_CH-1:0] = pend;
                else if (map_win)
                    rdata[CH_W-1:0] = map_q[int'(moff)];
            end
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/evr_status.sv
module evr_status
    import evr_pkg::*;
#(
    parameter int NUM_EVT = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] sys_evt,
    input  idx_strobe_t        set_s,
    input  idx_strobe_t        clr_s,
    output logic [NUM_EVT-1:0] status
);

    logic [NUM_EVT-1:0] evt_d;

    always_ff @(posedge clk) begin
        if (rst) evt_d <= '0;
        else     evt_d <= sys_evt;
    end

    generate
        for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
            logic hit_set;
            logic hit_clr;
            logic st_q;

            assign hit_set = (sys_evt[i] & ~evt_d[i]) |
                             (set_s.vld && set_s.idx == IDX_MAX_W'(i));
            assign hit_clr = clr_s.vld && clr_s.idx == IDX_MAX_W'(i);

            // clear outranks any set in the same cycle
            always_ff @(posedge clk) begin
                if (rst)          st_q <= 1'b0;
                else if (hit_clr) st_q <= 1'b0;
                else if (hit_set) st_q <= 1'b1;
            end

            assign status[i] = st_q;
        end
    endgenerate

endmodule

// File: rtl/evr_route.sv
module evr_route #(
    parameter int NUM_EVT = 12,
    parameter int NUM_CH  = 16,
    parameter int CH_W    = 4
) (
    input  logic [NUM_EVT-1:0]           status,
    input  logic [NUM_EVT-1:0]           evt_en,
    input  logic [NUM_EVT-1:0][CH_W-1:0] map_q,
    output logic [NUM_CH-1:0]            pend
);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic acc;
            always_comb begin
                acc = 1'b0;
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (map_q[e] == CH_W'(ch))
                        acc = acc | (status[e] & evt_en[e]);
                end
            end
            assign pend[ch] = acc;
        end
    endgenerate

endmodule

// File: rtl/evr_host_out.sv
module evr_host_out #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pend,
    input  logic [NUM_CH-1:0] host_en,
    input  logic              glob_en,
    output logic [NUM_CH-1:0] host_irq
);

    always_ff @(posedge clk) begin
        if (rst) host_irq <= '0;
        else     host_irq <= pend & host_en & {NUM_CH{glob_en}};
    end

endmodule

// File: rtl/evr_router.sv
module evr_router
    import evr_pkg::*;
#(
    parameter int NUM_EVT   = 12,
    parameter int NUM_CORES = 2,
    localparam int NUM_CH   = HOSTS_PER_CORE * NUM_CORES,
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] sys_evt,
    input  logic               wr_en,
    input  logic [5:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [NUM_CH-1:0]  host_irq
);

    logic [NUM_EVT-1:0]           status_w;
    logic [NUM_CH-1:0]            pend_w;
    logic                         glob_en_w;
    logic [NUM_EVT-1:0]           evt_en_w;
    logic [NUM_CH-1:0]            host_en_w;
    logic [NUM_EVT-1:0][CH_W-1:0] map_w;
    idx_strobe_t                  set_w;
    idx_strobe_t                  clr_w;

    evr_regs #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH), .CH_W(CH_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .status(status_w), .pend(pend_w), .rdata(rdata),
        .glob_en(glob_en_w), .evt_en(evt_en_w), .host_en(host_en_w),
        .map_q(map_w), .set_s(set_w), .clr_s(clr_w)
    );

    evr_status #(.NUM_EVT(NUM_EVT)) status_i (
        .clk(clk), .rst(rst), .sys_evt(sys_evt),
        .set_s(set_w), .clr_s(clr_w), .status(status_w)
    );

    evr_route #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH), .CH_W(CH_W)) route_i (
        .status(status_w), .evt_en(evt_en_w), .map_q(map_w), .pend(pend_w)
    );

    evr_host_out #(.NUM_CH(NUM_CH)) host_i (
        .clk(clk), .rst(rst), .pend(pend_w), .host_en(host_en_w),
        .glob_en(glob_en_w), .host_irq(host_irq)
    );

endmodule

// File: rtl/evr_router_chk.sv
module evr_router_chk
    import evr_pkg::*;
#(
    parameter int NUM_EVT = 12,
    parameter int NUM_CH  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [5:0]         addr,
    input logic [31:0]        wdata,
    input logic [NUM_CH-1:0]  host_irq,
    input logic [NUM_EVT-1:0] status,
    input logic [NUM_CH-1:0]  pend,
    input logic [NUM_EVT-1:0] evt_en,
    input logic [NUM_CH-1:0]  host_en,
    input logic               glob_en
);

    logic [NUM_EVT-1:0] sel_mask;
    logic               idx_in;
    assign sel_mask = NUM_EVT'(1) << wdata[IDX_MAX_W-1:0];
    assign idx_in   = wdata < 32'(NUM_EVT);

    // R1
    rst_clean_chk: assert property (@(posedge clk)
        rst |=> (host_irq == '0 && status == '0 && !glob_en));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_CLR) |=> ((status & $past(status)) == $past(status)));

    // R3
    set_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SET && idx_in) |=> ((status & $past(sel_mask)) == $past(sel_mask)));

    // R4
    clr_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CLR && idx_in) |=> ((status & $past(sel_mask)) == '0));

    // R5
    pend_source_chk: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> ((status & evt_en) != '0));

    // R7
    glob_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> (host_irq == '0));

    // R7
    host_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend & host_en) == '0) |=> (host_irq == '0));

endmodule

bind evr_router evr_router_chk #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .host_irq(host_irq), .status(status_w), .pend(pend_w),
    .evt_en(evt_en_w), .host_en(host_en_w), .glob_en(glob_en_w)
);

// File: tb/evr_router_tb.sv
module evr_router_tb_top;
    import evr_pkg::*;

    localparam int NE = 12;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NE-1:0] sys_evt = '0;
    logic          wr_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] host_irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [NE-1:0] m_status  = '0;
    logic [NE-1:0] m_evt_en  = '0;
    logic [NC-1:0] m_host_en = '0;
    logic          m_glob    = 1'b0;
    logic [3:0]    m_map [NE];

    always #2 clk = ~clk;

    evr_router #(.NUM_EVT(NE), .NUM_CORES(2)) dut_i (
        .clk(clk), .rst(rst), .sys_evt(sys_evt), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .host_irq(host_irq)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [NC-1:0] exp_pend();
        logic [NC-1:0] p = '0;
        for (int e = 0; e < NE; e++)
            if (m_status[e] && m_evt_en[e]) p[m_map[e]] = 1'b1;
        return p;
    endfunction

    task automatic check_state(input string req);
        logic [31:0] d;
        @(negedge clk);
        rd(A_STATUS, d);
        cmp({req, " status"}, d, 32'(m_status));
        rd(A_PEND, d);
        cmp({req, " pend"}, d, 32'(exp_pend()));
        cmp({req, " host"}, 32'(host_irq), 32'(exp_pend() & m_host_en & {NC{m_glob}}));
    endtask

    task automatic pulse(input int e);
        @(negedge clk); sys_evt[e] = 1'b1;
        @(negedge clk); sys_evt[e] = 1'b0;
        m_status[e] = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int e = 0; e < NE; e++) m_map[e] = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        cmp("R1 host", 32'(host_irq), 32'd0);
        rd(A_CTRL, d);    cmp("R1 ctrl", d, 32'd0);
        rd(A_EVT_EN, d);  cmp("R1 evt_en", d, 32'd0);
        rd(A_HOST_EN, d); cmp("R1 host_en", d, 32'd0);
        for (int e = 0; e < NE; e++) begin
            rd(6'(A_MAP_BASE + e), d); cmp("R1 map", d, 32'd0);
        end
        check_state("R1");

        // R6 event while disabled is held
        wr(A_HOST_EN, 32'hFFFF); m_host_en = '1;
        wr(A_CTRL, 32'd1);       m_glob = 1'b1;
        wr(6'(A_MAP_BASE + 4), 32'd6); m_map[4] = 4'd6;
        pulse(4);
        check_state("R6 disabled");
        wr(A_EVT_EN, 32'h010); m_evt_en = 12'h010;
        check_state("R6 enabled");

        // R9 readback
        rd(A_EVT_EN, d);  cmp("R9 evt_en", d, 32'h010);
        rd(A_HOST_EN, d); cmp("R9 host_en", d, 32'hFFFF);
        rd(A_CTRL, d);    cmp("R9 ctrl", d, 32'd1);
        rd(6'(A_MAP_BASE + 4), d); cmp("R9 map", d, 32'd6);

        // R7 global and per-host gating
        wr(A_CTRL, 32'd0); m_glob = 1'b0;
        check_state("R7 glob off");
        wr(A_CTRL, 32'd1); m_glob = 1'b1;
        wr(A_HOST_EN, 32'hFFBF); m_host_en = 16'hFFBF;
        check_state("R7 host off");
        wr(A_HOST_EN, 32'hFFFF); m_host_en = '1;
        wr(A_CLR, 32'd4); m_status[4] = 1'b0;
        check_state("R4 clear");

        // R7 one-cycle lag from pending to host line
        wr(A_EVT_EN, 32'hFFF); m_evt_en = '1;
        wr(6'(A_MAP_BASE + 0), 32'd5); m_map[0] = 4'd5;
        @(negedge clk); sys_evt[0] = 1'b1;
        @(negedge clk); sys_evt[0] = 1'b0;
        rd(A_PEND, d);
        cmp("R7 pend first", d, 32'h20);
        cmp("R7 host lag", 32'(host_irq), 32'd0);
        @(negedge clk);
        cmp("R7 host next", 32'(host_irq), 32'h20);
        m_status[0] = 1'b1;
        wr(A_CLR, 32'd0); m_status[0] = 1'b0;
        check_state("R4 clear lag");

        // R3 set by index, out-of-range ignored
        wr(A_SET, 32'd7); m_status[7] = 1'b1;
        check_state("R3 set");
        wr(A_SET, 32'd12);
        wr(A_SET, 32'd15);
        wr(A_SET, 32'd31);
        check_state("R3 out of range");
        wr(A_CLR, 32'd7); m_status[7] = 1'b0;

        // R4 clear wins against a same-cycle edge; R2 held level no re-set
        wr(A_SET, 32'd2); m_status[2] = 1'b1;
        @(negedge clk);
        sys_evt[2] = 1'b1; wr_en = 1'b1; addr = A_CLR; wdata = 32'd2;
        @(negedge clk);
        wr_en = 1'b0; m_status[2] = 1'b0;
        check_state("R4 clear over edge");
        repeat (3) @(negedge clk);
        check_state("R2 level held");
        sys_evt[2] = 1'b0;
        check_state("R2 fall");

        // R5 shared channel
        wr(6'(A_MAP_BASE + 8), 32'd9); m_map[8] = 4'd9;
        wr(6'(A_MAP_BASE + 9), 32'd9); m_map[9] = 4'd9;
        pulse(8); pulse(9);
        check_state("R5 shared");
        wr(A_CLR, 32'd8); m_status[8] = 1'b0;
        check_state("R5 shared one left");
        wr(A_CLR, 32'd9); m_status[9] = 1'b0;
        check_state("R5 shared none");

        // R5 / R8 sweep of every event over three channels
        for (int e = 0; e < NE; e++) begin
            for (int v = 0; v < 3; v++) begin
                int ch;
                ch = (v == 0) ? e : (v == 1) ? (NC - 1 - e) : host_index(1, e % 8);
                wr(6'(A_MAP_BASE + e), 32'(ch)); m_map[e] = 4'(ch);
                pulse(e);
                check_state("R5 sweep");
                cmp("R8 one-to-one", 32'(host_irq), 32'd1 << ch);
                wr(A_CLR, 32'(e)); m_status[e] = 1'b0;
                check_state("R4 sweep clear");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule